// File: doc/BRIEF.md
# Precise Exception Capture and Fetch Redirect

This block is the trap controller of a five-stage in-order pipeline. Each cycle it looks at two fault flags: an arithmetic overflow raised by the instruction in the execute stage, and an undefined opcode raised by the instruction in the decode stage. When either flag is set, the block takes the exception in that same cycle. It kills the faulting instruction and everything younger than it by clearing the affected pipeline registers. It also loads the program counter with a handler address. Instructions older than the fault are left alone and drain normally.

At the next clock edge the block stores two values in its registers. The saved exception PC holds the faulting instruction's address plus one instruction step. The one-bit cause records which fault occurred. The handler address is fixed by default. A build option derives it from the cause instead, placing one entry per cause at a fixed stride from a vector base. When both faults arrive together, the block takes the one from the older instruction, which is the one in execute. This keeps the exceptions precise.

Top module: `pipe_exc_ctrl`

## Requirements
- R1: After reset, `epc` reads 0 and `cause` reads 0.
- R2: An overflow flag in execute raises `flush_ifid`, `flush_idex`, `flush_exmem` and `pc_redirect` in the same cycle. Clearing the EX/MEM control fields stops the faulting instruction from writing its destination register.
- R3: An undefined-opcode flag in decode with no overflow raises `flush_ifid`, `flush_idex` and `pc_redirect`. It leaves `flush_exmem` low, so the older instruction in execute completes.
- R4: At the clock edge on which an exception is taken, `epc` loads the faulting instruction's PC plus 4, modulo 2^32.
- R5: At the clock edge on which an exception is taken, `cause` loads 1 for an overflow or 0 for an undefined opcode.
- R6: If both flags are set in the same cycle, only the overflow is taken. `epc` then gets `ex_pc`+4, `cause` gets 1, and `flush_exmem` is high.
- R7: With VECTORED=0, `redirect_pc` is 0x80000180 for either cause.
- R8: With VECTORED=1, `redirect_pc` is 0xC0000000 for an undefined opcode and 0xC0000020 for an overflow.
- R9: `epc` and `cause` keep their values on every cycle in which no exception is taken.
- R10: With neither flag set, every flush output and `pc_redirect` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_ovf | input | 1 | Overflow detected by the instruction in execute |
| ex_pc | input | 32 | PC of the instruction in execute |
| id_undef | input | 1 | Undefined opcode detected by the instruction in decode |
| id_pc | input | 32 | PC of the instruction in decode |
| flush_ifid | output | 1 | Zero the IF/ID instruction field |
| flush_idex | output | 1 | Zero the ID/EX control fields |
| flush_exmem | output | 1 | Zero the EX/MEM control fields |
| pc_redirect | output | 1 | Load the PC with `redirect_pc` |
| redirect_pc | output | 32 | Handler address |
| epc | output | 32 | Saved exception PC (faulting PC + 4) |
| cause | output | 1 | Saved cause: 0 undefined opcode, 1 overflow |

## Verification
The bench drives an overflow on the execute-stage instruction and an undefined opcode on the decode-stage instruction in the very same cycle, using different PCs for the two. In that cycle it checks that `flush_exmem` is high. After the following edge it checks the saved state: the recorded PC must be the execute PC plus 4 and the cause must be 1. If the design took the younger fault, or merged the two, the saved state would show it.

// File: rtl/pipe_exc_pkg.sv
package pipe_exc_pkg;
   typedef enum logic {
      CAUSE_UNDEF = 1'b0,
      CAUSE_OVF   = 1'b1
   } exc_cause_e;
endpackage

// File: rtl/exc_prio.sv
module exc_prio
   import pipe_exc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ex_ovf,
   input  logic [XLEN-1:0] ex_pc,
   input  logic            id_undef,
   input  logic [XLEN-1:0] id_pc,
   output logic            take,
   output logic            kill_ex,
   output exc_cause_e      sel_cause,
   output logic [XLEN-1:0] sel_pc
);
   // the execute-stage instruction is older, so its fault wins
   always_comb begin
      take      = ex_ovf | id_undef;
      kill_ex   = ex_ovf;
      sel_cause = CAUSE_UNDEF;
      sel_pc    = id_pc;
      if (ex_ovf) begin
         sel_cause = CAUSE_OVF;
         sel_pc    = ex_pc;
      end
   end

   // R6
   both_pick_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_ovf && id_undef) |-> (sel_cause == CAUSE_OVF && sel_pc == ex_pc));
endmodule

// File: rtl/exc_vector.sv
module exc_vector
   import pipe_exc_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter bit              VECTORED   = 1'b0,
   parameter logic [XLEN-1:0] TRAP_ADDR  = XLEN'(32'h8000_0180),
   parameter logic [XLEN-1:0] VEC_BASE   = XLEN'(32'hC000_0000),
   parameter logic [XLEN-1:0] VEC_STRIDE = XLEN'(32'h0000_0020)
) (
   input  exc_cause_e      cause_in,
   output logic [XLEN-1:0] handler
);
   generate
      if (VECTORED) begin : g_vec
         always_comb begin
            handler = VEC_BASE;
            if (cause_in == CAUSE_OVF) handler = VEC_BASE + VEC_STRIDE;
         end
      end else begin : g_fixed
         assign handler = TRAP_ADDR;
      end
   endgenerate
endmodule

// File: rtl/exc_state.sv
module exc_state
   import pipe_exc_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int PC_STEP = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  exc_cause_e      cause_in,
   input  logic [XLEN-1:0] pc_in,
   output logic [XLEN-1:0] epc_q,
   output exc_cause_e      cause_q
);
   localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q   <= '0;
         cause_q <= CAUSE_UNDEF;
      end else if (take) begin
         epc_q   <= pc_in + STEP;
         cause_q <= cause_in;
      end
   end

   // R4
   epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (epc_q == $past(pc_in) + STEP));
   // R5
   cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (cause_q == $past(cause_in)));
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(epc_q) && $stable(cause_q)));
endmodule

// File: rtl/pipe_exc_ctrl.sv
module pipe_exc_ctrl
   import pipe_exc_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              PC_STEP    = 4,
   parameter bit              VECTORED   = 1'b0,
   parameter logic [XLEN-1:0] TRAP_ADDR  = XLEN'(32'h8000_0180),
   parameter logic [XLEN-1:0] VEC_BASE   = XLEN'(32'hC000_0000),
   parameter logic [XLEN-1:0] VEC_STRIDE = XLEN'(32'h0000_0020)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ex_ovf,
   input  logic [XLEN-1:0] ex_pc,
   input  logic            id_undef,
   input  logic [XLEN-1:0] id_pc,
   output logic            flush_ifid,
   output logic            flush_idex,
   output logic            flush_exmem,
   output logic            pc_redirect,
   output logic [XLEN-1:0] redirect_pc,
   output logic [XLEN-1:0] epc,
   output logic            cause
);
   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("pipe_exc_ctrl: XLEN must be at least 8");
      end
      if (PC_STEP <= 0) begin : g_bad_step
         $error("pipe_exc_ctrl: PC_STEP must be positive");
      end
   endgenerate

   logic            take;
   logic            kill_ex;
   exc_cause_e      sel_cause;
   logic [XLEN-1:0] sel_pc;
   exc_cause_e      cause_q;

   exc_prio #(.XLEN(XLEN)) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .ex_ovf   (ex_ovf),
      .ex_pc    (ex_pc),
      .id_undef (id_undef),
      .id_pc    (id_pc),
      .take     (take),
      .kill_ex  (kill_ex),
      .sel_cause(sel_cause),
      .sel_pc   (sel_pc)
   );

   exc_vector #(
      .XLEN      (XLEN),
      .VECTORED  (VECTORED),
      .TRAP_ADDR (TRAP_ADDR),
      .VEC_BASE  (VEC_BASE),
      .VEC_STRIDE(VEC_STRIDE)
   ) u_vec (
      .cause_in(sel_cause),
      .handler (redirect_pc)
   );

   exc_state #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .cause_in(sel_cause),
      .pc_in   (sel_pc),
      .epc_q   (epc),
      .cause_q (cause_q)
   );

   // fault in decode kills decode and fetch; fault in execute also kills execute
   assign flush_ifid  = take;
   assign flush_idex  = take;
   assign flush_exmem = kill_ex;
   assign pc_redirect = take;
   assign cause       = cause_q;

   // R10
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ex_ovf && !id_undef) |-> (!pc_redirect && !flush_ifid && !flush_idex && !flush_exmem));
   // R3
   older_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_undef && !ex_ovf) |-> (!flush_exmem && flush_idex && pc_redirect));
   // R2
   ovf_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ex_ovf |-> (flush_exmem && flush_idex && flush_ifid && pc_redirect));
endmodule

// File: tb/pipe_exc_ctrl_bench.sv
module pipe_exc_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ex_ovf = 1'b0;
   logic [31:0] ex_pc = '0;
   logic        id_undef = 1'b0;
   logic [31:0] id_pc = '0;
   logic        f_ifid, f_idex, f_exmem, redir, cause;
   logic [31:0] rpc, epc;
   logic        v_ifid, v_idex, v_exmem, v_redir, v_cause;
   logic [31:0] v_rpc, v_epc;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   pipe_exc_ctrl u_pipe_exc_ctrl (
      .clk(clk), .rst_n(rst_n), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
      .id_undef(id_undef), .id_pc(id_pc), .flush_ifid(f_ifid),
      .flush_idex(f_idex), .flush_exmem(f_exmem), .pc_redirect(redir),
      .redirect_pc(rpc), .epc(epc), .cause(cause));

   pipe_exc_ctrl #(.VECTORED(1'b1)) u_pipe_exc_ctrl_vec (
      .clk(clk), .rst_n(rst_n), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
      .id_undef(id_undef), .id_pc(id_pc), .flush_ifid(v_ifid),
      .flush_idex(v_idex), .flush_exmem(v_exmem), .pc_redirect(v_redir),
      .redirect_pc(v_rpc), .epc(v_epc), .cause(v_cause));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(logic ov, logic [31:0] xp, logic ud, logic [31:0] dp);
      @(negedge clk);
      ex_ovf = ov; ex_pc = xp; id_undef = ud; id_pc = dp;
      #1;
   endtask

   task automatic settle_edge();
      @(posedge clk); #1;
      ex_ovf = 1'b0; id_undef = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 epc", epc, 32'h0);
      check("R1 cause", {31'b0, cause}, 32'h0);
      drive(1'b0, 32'h10, 1'b0, 32'h14);
      check("R10 redirect", {31'b0, redir}, 32'h0);
      check("R10 flushes", {29'b0, f_ifid, f_idex, f_exmem}, 32'h0);
      settle_edge();
   endtask

   task automatic t_ovf();
      drive(1'b1, 32'h0000_004C, 1'b0, 32'h0000_0050);
      check("R2 flushes", {29'b0, f_ifid, f_idex, f_exmem}, 32'h7);
      check("R2 redirect", {31'b0, redir}, 32'h1);
      check("R7 ovf handler", rpc, 32'h8000_0180);
      check("R8 ovf vector", v_rpc, 32'hC000_0020);
      settle_edge();
      check("R4 epc ovf", epc, 32'h0000_0050);
      check("R5 cause ovf", {31'b0, cause}, 32'h1);
   endtask

   task automatic t_idle();
      for (int i = 0; i < 3; i++) begin
         drive(1'b0, 32'h900 + 32'(i), 1'b0, 32'hA00);
         check("R10 idle redirect", {28'b0, redir, f_ifid, f_idex, f_exmem}, 32'h0);
         settle_edge();
         check("R9 epc hold", epc, 32'h0000_0050);
         check("R9 cause hold", {31'b0, cause}, 32'h1);
      end
   endtask

   task automatic t_undef();
      drive(1'b0, 32'h0000_00FC, 1'b1, 32'h0000_0100);
      check("R3 flushes", {29'b0, f_ifid, f_idex, f_exmem}, 32'h6);
      check("R3 redirect", {31'b0, redir}, 32'h1);
      check("R7 undef handler", rpc, 32'h8000_0180);
      check("R8 undef vector", v_rpc, 32'hC000_0000);
      settle_edge();
      check("R4 epc undef", epc, 32'h0000_0104);
      check("R5 cause undef", {31'b0, cause}, 32'h0);
      check("R8 vec epc", v_epc, 32'h0000_0104);
   endtask

   task automatic t_both();
      drive(1'b1, 32'h0000_0200, 1'b1, 32'h0000_0204);
      check("R6 exmem flush", {31'b0, f_exmem}, 32'h1);
      check("R6 vector", v_rpc, 32'hC000_0020);
      settle_edge();
      check("R6 epc", epc, 32'h0000_0204);
      check("R6 cause", {31'b0, cause}, 32'h1);
      check("R6 vec cause", {31'b0, v_cause}, 32'h1);
   endtask

   task automatic t_wrap();
      drive(1'b1, 32'hFFFF_FFFC, 1'b0, 32'h0);
      settle_edge();
      check("R4 epc wrap", epc, 32'h0000_0000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_ovf();
      t_idle();
      t_undef();
      t_both();
      t_wrap();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end
endmodule